// File: doc/BRIEF.md
# Rotating-Priority Eight-Source Interrupt Controller

This block gathers interrupt requests from eight peripheral sources and presents at most one of them to a processor. It has a single interrupt line and a 3-bit source number. A rising edge on a source input records a request. A mask register can block any set of sources. An in-service register remembers which sources the processor has acknowledged and not yet finished, so that interrupts can nest.

Priority is circular. Software names one source as the lowest. The source after it (modulo 8) is then the highest, and the rest follow in ascending order around the ring. The order can be set directly or rotated by end-of-interrupt commands, and an automatic mode rotates it on every non-specific end-of-interrupt. A special mask mode removes the blocking effect of the in-service register. In that mode only the mask decides which sources may interrupt.

Software drives a write strobe, a 3-bit opcode and an 8-bit data byte. The opcodes are: 0 set mask, 1 set lowest source, 2 automatic rotation on/off, 3 special mask mode on/off, 4 non-specific end-of-interrupt, 5 non-specific end-of-interrupt with rotation, 6 specific end-of-interrupt, and 7 specific end-of-interrupt with rotation.

Top module: `rot_irq_ctrl`

## Requirements
- R1: After reset the mask is all zero, source 7 is lowest (so source 0 is highest), automatic rotation and special mask mode are off, no request or in-service bit is set, `irq_o` is 0 and `vec_o` is 0.
- R2: A 0-to-1 transition on `src_i[n]` sets request bit n at the next clock edge. A source held high produces no further request.
- R3: Opcode 0 loads the mask from `cmd_data_i`, where bit n at 1 blocks source n. `irq_o` is 0 whenever every pending request is masked. Clearing the mask bit releases a held-back request.
- R4: When `ack_i` is high while `irq_o` is high, the winning source moves from request to in-service, and `vec_o` shows its index from the next cycle. When `ack_i` is high while `irq_o` is 0, nothing changes.
- R5: Opcode 1 makes `cmd_data_i[2:0]` the lowest source L. Priority then falls from L+1 through L+8 (modulo 8).
- R6: With special mask mode off, `irq_o` is raised only for an unmasked request whose priority is strictly above that of every in-service source.
- R7: Opcode 3 with `cmd_data_i[0]`=1 turns on special mask mode. In that mode any unmasked request that is not itself in service raises `irq_o`, whatever else is in service.
- R8: Opcode 4 clears the highest-priority in-service bit.
- R9: Opcode 6 clears the in-service bit whose index is `cmd_data_i[2:0]`.
- R10: Opcodes 5 and 7 clear a bit as opcodes 4 and 6 do. They also make the cleared source the lowest.
- R11: Opcode 2 with `cmd_data_i[0]`=1 turns on automatic rotation. In that mode opcode 4 also makes the cleared source the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 8 | Request inputs, rising-edge sensitive |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_op_i | input | 3 | Command opcode (0 to 7, see above) |
| cmd_data_i | input | 8 | Command data byte |
| ack_i | input | 1 | Processor acknowledge |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Index of the most recently acknowledged source |

## Verification
The main sweep fires all eight sources at once under each of the eight lowest-source settings. It then acknowledges and retires the sources one by one, which pins down every rotation of the ring.

Short directed patterns cover the other behaviours:
- Nesting of a higher source over a lower one, and holding off an equal or lower one.
- Masked requests, and a level held high.
- Specific clears of a non-top in-service bit, whose effect shows only in which later request is let through.
- Rotating clears, automatic rotation and special mask mode. Each of these produces a winning order that differs from the plain ordering, so a misplaced rotation or a blocking in-service bit changes the observed vector.

// File: rtl/ric_pkg.sv
package ric_pkg;
  localparam int NSRC = 8;
  localparam int IW   = $clog2(NSRC);

  typedef enum logic [2:0] {
    OP_MASK     = 3'd0,
    OP_LOWEST   = 3'd1,
    OP_AUTOROT  = 3'd2,
    OP_SMM      = 3'd3,
    OP_EOI_NS   = 3'd4,
    OP_EOI_NSR  = 3'd5,
    OP_EOI_SP   = 3'd6,
    OP_EOI_SPR  = 3'd7
  } op_e;

  // distance from the highest slot: 0 = highest, NSRC-1 = lowest
  function automatic logic [IW-1:0] rank_of(input logic [IW-1:0] src,
                                            input logic [IW-1:0] low);
    return src - low - IW'(1);
  endfunction

  // pick highest-priority set bit; result is {found, index}
  function automatic logic [IW:0] pick_top(input logic [NSRC-1:0] vec,
                                           input logic [IW-1:0]  low);
    logic [IW:0]   r;
    logic [IW-1:0] idx;
    r = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      idx = low + IW'(1) + IW'(k);
      if (vec[idx]) r = {1'b1, idx};
    end
    return r;
  endfunction

  function automatic logic [NSRC-1:0] onehot(input logic [IW-1:0] idx);
    return NSRC'(1) << idx;
  endfunction
endpackage

// File: rtl/ric_req_capture.sv
module ric_req_capture
  import ric_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] req_o
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] rise;

  assign rise  = src_i & ~prev_q;
  assign req_o = req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= src_i;
      req_q  <= (req_q & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/ric_resolver.sv
module ric_resolver
  import ric_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] isr_i,
  input  logic [IW-1:0]   low_i,
  input  logic            smm_i,
  output logic            irq_o,
  output logic [IW-1:0]   win_idx_o,
  output logic            isr_top_found_o,
  output logic [IW-1:0]   isr_top_idx_o
);
  logic [NSRC-1:0] eligible;
  logic [IW:0]     win;
  logic [IW:0]     itop;
  logic            beats_isr;

  assign eligible        = req_i & ~mask_i & ~isr_i;
  assign win             = pick_top(eligible, low_i);
  assign itop            = pick_top(isr_i, low_i);
  assign win_idx_o       = win[IW-1:0];
  assign isr_top_found_o = itop[IW];
  assign isr_top_idx_o   = itop[IW-1:0];
  assign beats_isr       = !itop[IW] ||
                           (rank_of(win[IW-1:0], low_i) < rank_of(itop[IW-1:0], low_i));
  assign irq_o           = win[IW] && (smm_i || beats_isr);
endmodule

// File: rtl/ric_ctrl.sv
module ric_ctrl
  import ric_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [2:0]      op_i,
  input  logic [7:0]      data_i,
  input  logic            isr_top_found_i,
  input  logic [IW-1:0]   isr_top_idx_i,
  output logic [NSRC-1:0] mask_o,
  output logic [IW-1:0]   low_o,
  output logic            smm_o,
  output logic [NSRC-1:0] eoi_clr_o,
  output logic [IW-1:0]   eoi_idx_o,
  output logic            rotate_fire_o
);
  logic [NSRC-1:0] mask_q;
  logic [IW-1:0]   low_q;
  logic            autorot_q;
  logic            smm_q;
  logic            eoi_cmd;
  logic            specific;
  logic            rot_req;
  logic            eoi_hit;

  assign eoi_cmd       = we_i && op_i[2];
  assign specific      = op_i[1];
  assign rot_req       = op_i[0] || (autorot_q && !op_i[1]);
  assign eoi_idx_o     = specific ? data_i[IW-1:0] : isr_top_idx_i;
  assign eoi_hit       = eoi_cmd && (specific || isr_top_found_i);
  assign eoi_clr_o     = eoi_hit ? onehot(eoi_idx_o) : '0;
  assign rotate_fire_o = eoi_hit && rot_req;
  assign mask_o        = mask_q;
  assign low_o         = low_q;
  assign smm_o         = smm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      low_q     <= IW'(NSRC - 1);
      autorot_q <= 1'b0;
      smm_q     <= 1'b0;
    end else if (we_i) begin
      case (op_e'(op_i))
        OP_MASK:    mask_q    <= data_i[NSRC-1:0];
        OP_LOWEST:  low_q     <= data_i[IW-1:0];
        OP_AUTOROT: autorot_q <= data_i[0];
        OP_SMM:     smm_q     <= data_i[0];
        default:    if (rotate_fire_o) low_q <= eoi_idx_o;
      endcase
    end
  end
endmodule

// File: rtl/rot_irq_ctrl.sv
module rot_irq_ctrl
  import ric_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] src_i,
  input  logic       cmd_we_i,
  input  logic [2:0] cmd_op_i,
  input  logic [7:0] cmd_data_i,
  input  logic       ack_i,
  output logic       irq_o,
  output logic [2:0] vec_o
);
  logic [NSRC-1:0] req_q;
  logic [NSRC-1:0] isr_q;
  logic [NSRC-1:0] mask_q;
  logic [IW-1:0]   low_q;
  logic            smm_q;
  logic [IW-1:0]   win_idx;
  logic            isr_top_found;
  logic [IW-1:0]   isr_top_idx;
  logic [NSRC-1:0] eoi_clr;
  logic [IW-1:0]   eoi_idx;
  logic            rotate_fire;
  logic            ack_fire;
  logic [NSRC-1:0] win_onehot;
  logic [NSRC-1:0] ack_set;
  logic [IW-1:0]   vec_q;

  assign ack_fire   = ack_i && irq_o;
  assign win_onehot = onehot(win_idx);
  assign ack_set    = ack_fire ? win_onehot : '0;
  assign vec_o      = vec_q;

  ric_req_capture u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .clr_i (ack_set),
    .req_o (req_q)
  );

  ric_resolver u_res (
    .req_i           (req_q),
    .mask_i          (mask_q),
    .isr_i           (isr_q),
    .low_i           (low_q),
    .smm_i           (smm_q),
    .irq_o           (irq_o),
    .win_idx_o       (win_idx),
    .isr_top_found_o (isr_top_found),
    .isr_top_idx_o   (isr_top_idx)
  );

  ric_ctrl u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .we_i            (cmd_we_i),
    .op_i            (cmd_op_i),
    .data_i          (cmd_data_i),
    .isr_top_found_i (isr_top_found),
    .isr_top_idx_i   (isr_top_idx),
    .mask_o          (mask_q),
    .low_o           (low_q),
    .smm_o           (smm_q),
    .eoi_clr_o       (eoi_clr),
    .eoi_idx_o       (eoi_idx),
    .rotate_fire_o   (rotate_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      vec_q <= '0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | ack_set;
      if (ack_fire) vec_q <= win_idx;
    end
  end
endmodule

// File: rtl/ric_checker.sv
module ric_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_o,
  input logic [2:0] vec_o,
  input logic       ack_fire,
  input logic [2:0] win_idx,
  input logic [7:0] req_q,
  input logic [7:0] isr_q,
  input logic [7:0] mask_q,
  input logic [7:0] eoi_clr,
  input logic [2:0] eoi_idx,
  input logic [2:0] low_q,
  input logic       rotate_fire
);
  AST_VEC_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> vec_o == $past(win_idx)); // R4
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr_q[$past(win_idx)]); // R4
  AST_NO_ISR_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fire |=> (isr_q & ~$past(isr_q)) == 8'h00); // R4
  AST_IRQ_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> req_q[win_idx] && !mask_q[win_idx]); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~mask_q) == 8'h00) |-> !irq_o); // R3
  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_clr != 8'h00 && !ack_fire) |=> (isr_q & $past(eoi_clr)) == 8'h00); // R8
  AST_ROT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    rotate_fire |=> low_q == $past(eoi_idx)); // R10
endmodule

bind rot_irq_ctrl ric_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .ack_fire    (ack_fire),
  .win_idx     (win_idx),
  .req_q       (req_q),
  .isr_q       (isr_q),
  .mask_q      (mask_q),
  .eoi_clr     (eoi_clr),
  .eoi_idx     (eoi_idx),
  .low_q       (low_q),
  .rotate_fire (rotate_fire)
);

// File: tb/sim_rot_irq_ctrl.sv
module sim_rot_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src = '0;
  logic       we = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] data = '0;
  logic       ack = 1'b0;
  logic       irq;
  logic [2:0] vec;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .cmd_we_i(we),
    .cmd_op_i(op), .cmd_data_i(data), .ack_i(ack),
    .irq_o(irq), .vec_o(vec)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cmd(input int o, input int d);
    we = 1'b1; op = 3'(o); data = 8'(d);
    @(negedge clk);
    we = 1'b0; op = '0; data = '0;
  endtask

  task automatic pulse(input logic [7:0] m);
    src = src | m;
    @(negedge clk);
    src = src & ~m;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 vec after reset", int'(vec), 0);

    // sweep every lowest-source setting; first pass uses reset default
    for (int li = 0; li < 8; li++) begin
      int lo;
      lo = (li + 7) % 8;
      if (li != 0) cmd(1, lo);
      pulse(8'hFF);
      for (int k = 0; k < 8; k++) begin
        chk("R5 irq with pending", int'(irq), 1);
        do_ack();
        chk("R5 service order", int'(vec), (lo + 1 + k) % 8);
        chk("R6 lower held off", int'(irq), 0);
        cmd(4, 0);
      end
      chk("R4 requests drained", int'(irq), 0);
    end
    cmd(1, 7);

    // nesting under normal mode
    pulse(8'h20); do_ack();
    chk("R4 vec 5", int'(vec), 5);
    pulse(8'h04);
    chk("R6 higher nests", int'(irq), 1);
    do_ack();
    chk("R6 vec 2", int'(vec), 2);
    pulse(8'h40);
    chk("R6 lower blocked", int'(irq), 0);
    cmd(4, 0);
    chk("R8 top cleared, 5 still blocks 6", int'(irq), 0);
    cmd(4, 0);
    chk("R8 5 cleared releases 6", int'(irq), 1);
    do_ack();
    chk("R8 vec 6", int'(vec), 6);
    cmd(4, 0);
    pulse(8'h08); do_ack();
    pulse(8'h08);
    chk("R6 equal priority blocked", int'(irq), 0);
    cmd(4, 0);
    chk("R6 released after EOI", int'(irq), 1);
    do_ack(); cmd(4, 0);

    // mask and held level
    cmd(0, 8'h10);
    pulse(8'h10);
    chk("R3 masked quiet", int'(irq), 0);
    cmd(0, 0);
    chk("R3 unmask releases", int'(irq), 1);
    do_ack();
    chk("R3 vec 4", int'(vec), 4);
    cmd(4, 0);
    src = 8'h02; @(negedge clk);
    chk("R2 edge raises irq", int'(irq), 1);
    do_ack(); cmd(4, 0);
    @(negedge clk);
    chk("R2 held level no repeat", int'(irq), 0);
    src = 8'h00;

    // ignored acknowledge
    do_ack();
    chk("R4 ignored ack keeps vec", int'(vec), 1);
    pulse(8'h80);
    chk("R4 ignored ack took nothing", int'(irq), 1);
    do_ack();
    chk("R4 vec 7", int'(vec), 7);
    cmd(4, 0);

    // specific EOI
    pulse(8'h40); do_ack();
    pulse(8'h02); do_ack();
    cmd(6, 1);
    pulse(8'h08);
    chk("R9 specific clears 1, 3 beats 6", int'(irq), 1);
    do_ack();
    chk("R9 vec 3", int'(vec), 3);
    cmd(6, 6);
    cmd(4, 0);
    pulse(8'h80);
    chk("R9 6 cleared lets 7 in", int'(irq), 1);
    do_ack(); cmd(4, 0);

    // rotating EOI forms
    pulse(8'h04); do_ack();
    cmd(7, 2);
    pulse(8'h0A);
    do_ack();
    chk("R10 specific rotate, 3 first", int'(vec), 3);
    cmd(4, 0); do_ack();
    chk("R10 then 1", int'(vec), 1);
    cmd(4, 0);
    cmd(1, 7);
    pulse(8'h10); do_ack();
    cmd(5, 0);
    pulse(8'h28);
    do_ack();
    chk("R10 non-specific rotate, 5 first", int'(vec), 5);
    cmd(4, 0); do_ack();
    chk("R10 then 3", int'(vec), 3);
    cmd(4, 0);

    // automatic rotation
    cmd(1, 7); cmd(2, 1);
    pulse(8'h03); do_ack();
    chk("R11 vec 0", int'(vec), 0);
    cmd(4, 0);
    pulse(8'h01);
    do_ack();
    chk("R11 rotated, 1 before 0", int'(vec), 1);
    cmd(4, 0); do_ack();
    chk("R11 then 0", int'(vec), 0);
    cmd(4, 0);
    cmd(2, 0); cmd(1, 7);

    // special mask mode
    cmd(3, 1);
    pulse(8'h04); do_ack();
    pulse(8'h20);
    chk("R7 lower allowed in special mode", int'(irq), 1);
    do_ack();
    chk("R7 vec 5", int'(vec), 5);
    pulse(8'h04);
    chk("R7 in-service source blocked", int'(irq), 0);
    cmd(0, 8'h08); pulse(8'h08);
    chk("R7 mask still applies", int'(irq), 0);
    cmd(4, 0);
    chk("R7 source 2 after its EOI", int'(irq), 1);
    do_ack();
    chk("R7 vec 2", int'(vec), 2);
    cmd(4, 0); cmd(4, 0); cmd(0, 0);
    do_ack();
    chk("R7 vec 3 after unmask", int'(vec), 3);
    cmd(4, 0); cmd(3, 0);
    chk("R1 idle at end", int'(irq), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule